// File: doc/BRIEF.md
# Antiphase Sine PWM Generator for a Full Bridge

This block produces the four gate commands of a two-leg full bridge from a triangular carrier and a sine reference. A counter runs on the comparator clock, climbing from 0 to `HALF-1` and falling back to 0, so one switching period lasts `2*HALF` clocks. At the end of every period a new duty value is computed for each leg from a sine table, a fixed-point modulation depth and a signed correction word from the control loop. The duty values go into the registers that govern the following period.

Leg A follows the sine plus a mid-scale offset. Leg B uses the negated sine, which is the same waveform half a cycle later, and the correction enters it with the opposite sign. The two legs therefore switch in antiphase, and the bridge output carries two pulses per switching period. Each leg drives a complementary pair of gates with a programmable blanking interval between them. A single-cycle trigger marks the start of every period, so sampling and the control update can be scheduled from it.

The sine table is built at elaboration from a rational approximation and needs no stored constants. Gate outputs are registered.

Top module: `spwm_bridge`

## Requirements
- R1: `trig_o` is high for exactly one clock at the first cycle of each switching period, and the period is `2*HALF` clocks.
- R2: In a period with sine index k, the raw on-interval of leg A lasts `2*dA` clocks and is centred on the carrier peak. `dA = HALF/2 + (HALF/2)*M*sin(2*pi*k/STEPS) + corr`, with `M = mod_i/32768` (unsigned Q1.15) and `corr` the signed `corr_i` in carrier counts, and `dA` is accurate to within one count.
- R3: Leg B uses `dB = HALF/2 - (HALF/2)*M*sin(2*pi*k/STEPS) - corr`, which is the leg A sine advanced by half a cycle.
- R4: The sine index is 0 in the period that begins at the first trigger after reset. It advances by one at every later trigger and returns to 0 after `STEPS-1`.
- R5: Each duty is clamped to the range 0 to `HALF`. At `HALF` the high gate stays on for the whole period, and at 0 it stays off for the whole period.
- R6: The high and low gate of a leg are never on together. After every change of the raw leg state, both gates stay off for `dead_i` clocks. The high gate is therefore on for `2*d - dead_i` clocks per period, and the low gate for `2*HALF - 2*d - dead_i` clocks.
- R7: With `dead_i = 0` the low gate is the exact complement of the high gate. The high gate is then on for `2*d` clocks per period.
- R8: `mod_i` and `corr_i` are sampled only on the last clock of a period. A change made earlier within a period has no effect on that period and governs the next one.
- R9: While `rst` is high, all four gates and `trig_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Comparator clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_i | input | MOD_W | Modulation depth, unsigned Q1.15 (32768 = 1.0) |
| corr_i | input | CORR_W | Signed duty correction in carrier counts |
| dead_i | input | DT_W | Blanking interval in clocks |
| trig_o | output | 1 | One-clock pulse at the start of each period |
| hi_a_o | output | 1 | Leg A high-side gate |
| lo_a_o | output | 1 | Leg A low-side gate |
| hi_b_o | output | 1 | Leg B high-side gate |
| lo_b_o | output | 1 | Leg B low-side gate |

## Verification
A carrier that turns at the wrong count or misses its turn shows within one period: the trigger spacing drifts away from `2*HALF`, and the pulses are no longer centred in their window. A wrong sine index or a bad table entry changes the on-time of both legs in that period, and both deviate in opposite directions. An index that fails to wrap shows only after `STEPS` periods, so the run covers more than a full sine cycle. A faulty blanking counter shows in the next switching edge, either as overlapping gates or as on-times that are off by the dead interval.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

    // Signed Q1.15 sine of phase 2*pi*p/steps from a rational
    // half-wave approximation: 16u(1-u)/(5-4u(1-u)), u = phase/pi.
    function automatic int sine_q15(input int p, input int steps);
        longint h;
        longint q;
        longint a;
        longint v;
        bit     neg;
        h   = longint'(steps / 2);
        neg = (longint'(p) >= h);
        q   = neg ? longint'(p) - h : longint'(p);
        a   = q * (h - q);
        v   = (64'sd16 * 64'sd32768 * a) / (64'sd5 * h * h - 64'sd4 * a);
        return neg ? -int'(v) : int'(v);
    endfunction

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
    parameter int HALF  = 64,
    parameter int STEPS = 16,
    parameter int CNT_W = $clog2(HALF + 1),
    parameter int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o,
    output logic             trig_o,
    output logic [IDX_W-1:0] idx_o
);
    import spwm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
        logic             trig;
        logic [IDX_W-1:0] idx;
    } car_t;

    car_t car_d, car_q;
    logic last;

    always_comb begin
        car_d      = car_q;
        car_d.trig = 1'b0;
        last       = (car_q.dir == DIR_DOWN) && (car_q.cnt == '0);
        if (car_q.dir == DIR_UP) begin
            if (car_q.cnt == CNT_W'(HALF - 1)) begin
                car_d.dir = DIR_DOWN;
            end else begin
                car_d.cnt = car_q.cnt + 1'b1;
            end
        end else if (last) begin
            car_d.dir  = DIR_UP;
            car_d.trig = 1'b1;
            car_d.idx  = (car_q.idx == IDX_W'(STEPS - 1)) ? '0 : car_q.idx + 1'b1;
        end else begin
            car_d.cnt = car_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= '{cnt: '0, dir: DIR_UP, trig: 1'b0, idx: '0};
        end else begin
            car_q <= car_d;
        end
    end

    assign cnt_o  = car_q.cnt;
    assign last_o = last;
    assign trig_o = car_q.trig;
    assign idx_o  = car_q.idx;

endmodule

// File: rtl/spwm_duty.sv
module spwm_duty #(
    parameter int HALF   = 64,
    parameter int STEPS  = 16,
    parameter int MOD_W  = 16,
    parameter int CORR_W = 8,
    parameter int CNT_W  = $clog2(HALF + 1),
    parameter int IDX_W  = $clog2(STEPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [MOD_W-1:0]         mod_i,
    input  logic signed [CORR_W-1:0] corr_i,
    output logic [CNT_W-1:0]         duty_a_o,
    output logic [CNT_W-1:0]         duty_b_o
);
    import spwm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b;
    } duty_t;

    duty_t duty_d, duty_q;

    logic signed [17:0] lut [STEPS];

    for (genvar g = 0; g < STEPS; g++) begin : g_lut
        localparam int SV = sine_q15(g, STEPS);
        assign lut[g] = 18'(SV);
    end

    function automatic logic [CNT_W-1:0] clamp(input longint v);
        if (v < 0) return '0;
        if (v > longint'(HALF)) return CNT_W'(HALF);
        return CNT_W'(v);
    endfunction

    longint prod;
    longint term_a;
    longint term_b;

    always_comb begin
        duty_d = duty_q;
        prod   = longint'(mod_i) * longint'(lut[idx_i]) * longint'(HALF);
        term_a = prod >>> 31;
        term_b = (-prod) >>> 31;
        if (load_i) begin
            duty_d.a = clamp(longint'(HALF / 2) + term_a + longint'(corr_i));
            duty_d.b = clamp(longint'(HALF / 2) + term_b - longint'(corr_i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '{a: CNT_W'(HALF / 2), b: CNT_W'(HALF / 2)};
        end else begin
            duty_q <= duty_d;
        end
    end

    assign duty_a_o = duty_q.a;
    assign duty_b_o = duty_q.b;

endmodule

// File: rtl/spwm_gate.sv
module spwm_gate #(
    parameter int HALF  = 64,
    parameter int DT_W  = 6,
    parameter int CNT_W = $clog2(HALF + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             hi_o,
    output logic             lo_o
);
    typedef struct packed {
        logic            raw;
        logic [DT_W-1:0] dead;
        logic            hi;
        logic            lo;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  raw;

    always_comb begin
        // high while cnt >= HALF - duty: pulse centred on the carrier peak
        raw        = ((CNT_W+1)'(cnt_i) + (CNT_W+1)'(duty_i)) >= (CNT_W+1)'(HALF);
        gate_d     = gate_q;
        gate_d.raw = raw;
        if (raw != gate_q.raw) begin
            if (dead_i == '0) begin
                gate_d.hi   = raw;
                gate_d.lo   = !raw;
                gate_d.dead = '0;
            end else begin
                gate_d.hi   = 1'b0;
                gate_d.lo   = 1'b0;
                gate_d.dead = dead_i - 1'b1;
            end
        end else if (gate_q.dead != '0) begin
            gate_d.hi   = 1'b0;
            gate_d.lo   = 1'b0;
            gate_d.dead = gate_q.dead - 1'b1;
        end else begin
            gate_d.hi = raw;
            gate_d.lo = !raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '{raw: 1'b0, dead: '0, hi: 1'b0, lo: 1'b0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign hi_o = gate_q.hi;
    assign lo_o = gate_q.lo;

endmodule

// File: rtl/spwm_bridge.sv
module spwm_bridge #(
    parameter int HALF   = 64,
    parameter int STEPS  = 16,
    parameter int MOD_W  = 16,
    parameter int CORR_W = 8,
    parameter int DT_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [MOD_W-1:0]         mod_i,
    input  logic signed [CORR_W-1:0] corr_i,
    input  logic [DT_W-1:0]          dead_i,
    output logic                     trig_o,
    output logic                     hi_a_o,
    output logic                     lo_a_o,
    output logic                     hi_b_o,
    output logic                     lo_b_o
);
    localparam int CNT_W = $clog2(HALF + 1);
    localparam int IDX_W = $clog2(STEPS);
    localparam int LEGS  = 2;

    logic [CNT_W-1:0] cnt;
    logic             last;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] duty_a;
    logic [CNT_W-1:0] duty_b;
    logic [LEGS-1:0][CNT_W-1:0] duty_pk;
    logic [LEGS-1:0] hi;
    logic [LEGS-1:0] lo;

    spwm_carrier #(.HALF(HALF), .STEPS(STEPS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_car (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .last_o (last),
        .trig_o (trig_o),
        .idx_o  (idx)
    );

    spwm_duty #(.HALF(HALF), .STEPS(STEPS), .MOD_W(MOD_W), .CORR_W(CORR_W),
                .CNT_W(CNT_W), .IDX_W(IDX_W)) u_duty (
        .clk      (clk),
        .rst      (rst),
        .load_i   (last),
        .idx_i    (idx),
        .mod_i    (mod_i),
        .corr_i   (corr_i),
        .duty_a_o (duty_a),
        .duty_b_o (duty_b)
    );

    assign duty_pk = {duty_b, duty_a};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        spwm_gate #(.HALF(HALF), .DT_W(DT_W), .CNT_W(CNT_W)) u_gate (
            .clk    (clk),
            .rst    (rst),
            .cnt_i  (cnt),
            .duty_i (duty_pk[g]),
            .dead_i (dead_i),
            .hi_o   (hi[g]),
            .lo_o   (lo[g])
        );
    end

    assign hi_a_o = hi[0];
    assign lo_a_o = lo[0];
    assign hi_b_o = hi[1];
    assign lo_b_o = lo[1];

endmodule

// File: rtl/spwm_bridge_chk.sv
module spwm_bridge_chk #(
    parameter int HALF  = 64,
    parameter int CNT_W = 7,
    parameter int DT_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             trig,
    input logic             hi_a,
    input logic             lo_a,
    input logic             hi_b,
    input logic             lo_b,
    input logic [DT_W-1:0]  dead,
    input logic [CNT_W-1:0] duty_a,
    input logic [CNT_W-1:0] duty_b
);
    localparam int SPAN_W = CNT_W + 1;

    logic [SPAN_W-1:0] since_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (trig) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_trig_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (trig && seen_q) |-> (since_q == SPAN_W'(2 * HALF - 1)));

    p_trig_due_r1: assert property (@(posedge clk) disable iff (rst)
        (seen_q && since_q == SPAN_W'(2 * HALF - 1)) |-> trig);

    p_duty_range_r5: assert property (@(posedge clk) disable iff (rst)
        (duty_a <= CNT_W'(HALF)) && (duty_b <= CNT_W'(HALF)));

    p_no_shoot_r6: assert property (@(posedge clk) disable iff (rst)
        !(hi_a && lo_a) && !(hi_b && lo_b));

    p_gap_a_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(hi_a) && dead >= DT_W'(2)) |=> !lo_a);

    p_gap_b_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(lo_b) && dead >= DT_W'(2)) |=> !hi_b);

    p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !trig |-> ($stable(duty_a) && $stable(duty_b)));

    p_reset_off_r9: assert property (@(posedge clk)
        rst |=> (!hi_a && !lo_a && !hi_b && !lo_b && !trig));

endmodule

bind spwm_bridge spwm_bridge_chk #(.HALF(HALF), .CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .trig   (trig_o),
    .hi_a   (hi_a_o),
    .lo_a   (lo_a_o),
    .hi_b   (hi_b_o),
    .lo_b   (lo_b_o),
    .dead   (dead_i),
    .duty_a (duty_a),
    .duty_b (duty_b)
);

// File: tb/sim_spwm_bridge.sv
module sim_spwm_bridge;
    localparam int CLK_NS = 10;
    localparam int HALF   = 64;
    localparam int STEPS  = 16;
    localparam int MOD_W  = 16;
    localparam int CORR_W = 8;
    localparam int DT_W   = 6;
    localparam real TOL   = 2.5;
    localparam int NVEC   = 6;
    // mod, corr, dead, measured periods
    localparam int VEC [NVEC][4] = '{
        '{19661,  0, 4, 18},
        '{29491,  0, 2,  4},
        '{0,      0, 2,  2},
        '{16384, 10, 6,  4},
        '{19661, -8, 3,  4},
        '{19661,  0, 0,  3}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [MOD_W-1:0]         mod_i = '0;
    logic signed [CORR_W-1:0] corr_i = '0;
    logic [DT_W-1:0]          dead_i = '0;
    logic trig_o, hi_a_o, lo_a_o, hi_b_o, lo_b_o;

    int errors = 0;
    int checks = 0;
    int trigs  = 0;

    spwm_bridge #(.HALF(HALF), .STEPS(STEPS), .MOD_W(MOD_W), .CORR_W(CORR_W), .DT_W(DT_W)) u0 (
        .clk(clk), .rst(rst), .mod_i(mod_i), .corr_i(corr_i), .dead_i(dead_i),
        .trig_o(trig_o), .hi_a_o(hi_a_o), .lo_a_o(lo_a_o), .hi_b_o(hi_b_o), .lo_b_o(lo_b_o)
    );

    always #(CLK_NS / 2) clk = ~clk;

    function automatic real exp_duty(input int k, input int m, input int c, input bit leg_b);
        real s;
        real d;
        s = $sin(2.0 * 3.14159265358979 * real'(k) / real'(STEPS));
        if (leg_b) begin
            s = -s;
            c = -c;
        end
        d = real'(HALF) / 2.0 + (real'(HALF) / 2.0) * (real'(m) / 32768.0) * s + real'(c);
        if (d < 0.0) d = 0.0;
        if (d > real'(HALF)) d = real'(HALF);
        return d;
    endfunction

    task automatic check_near(input string tag, input int act, input real expv, input real tol);
        real diff;
        checks++;
        diff = real'(act) - expv;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0.2f", tag, act, expv);
        end
    endtask

    // Starts at a negedge where trig_o is high; ends at the next such negedge.
    task automatic measure(input int chg_pos, input int new_corr,
                           output int ha, output int la, output int hb, output int lb,
                           output int k, output int tbad);
        ha = 0; la = 0; hb = 0; lb = 0; tbad = 0; k = 0;
        for (int i = 0; i < 2 * HALF; i++) begin
            if (i == chg_pos) corr_i = CORR_W'(new_corr);
            if (trig_o) begin
                trigs++;
                if (i != 0) tbad++;
            end else if (i == 0) begin
                tbad++;
            end
            if (i == 0) k = (trigs - 1) % STEPS;
            ha += int'(hi_a_o);
            la += int'(lo_a_o);
            hb += int'(hi_b_o);
            lb += int'(lo_b_o);
            @(negedge clk);
        end
    endtask

    task automatic check_period(input int m, input int c, input int dt,
                                input int chg_pos, input int new_corr);
        int ha, la, hb, lb, k, tbad;
        real da, db;
        measure(chg_pos, new_corr, ha, la, hb, lb, k, tbad);
        da = exp_duty(k, m, c, 1'b0);
        db = exp_duty(k, m, c, 1'b1);
        check_near("R1 trigger once at period start", tbad, 0.0, 0.0);
        check_near("R2 R4 R6 leg A high time", ha, 2.0 * da - real'(dt), TOL);
        check_near("R6 leg A low time", la, 2.0 * real'(HALF) - 2.0 * da - real'(dt), TOL);
        check_near("R3 R4 R6 leg B high time", hb, 2.0 * db - real'(dt), TOL);
        check_near("R6 leg B low time", lb, 2.0 * real'(HALF) - 2.0 * db - real'(dt), TOL);
        if (dt == 0) begin
            check_near("R7 leg A exact complement", ha + la, real'(2 * HALF), 0.0);
            check_near("R7 leg B exact complement", hb + lb, real'(2 * HALF), 0.0);
        end
    endtask

    task automatic skip_period();
        int ha, la, hb, lb, k, tbad;
        measure(-1, 0, ha, la, hb, lb, k, tbad);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ha, la, hb, lb, k, tbad;
        // R9: reset state
        repeat (4) @(negedge clk);
        check_near("R9 gates off in reset", int'(hi_a_o) + int'(lo_a_o) + int'(hi_b_o) + int'(lo_b_o), 0.0, 0.0);
        check_near("R9 trigger low in reset", int'(trig_o), 0.0, 0.0);
        rst = 1'b0;
        while (!trig_o) @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            mod_i  = MOD_W'(VEC[v][0]);
            corr_i = CORR_W'(VEC[v][1]);
            dead_i = DT_W'(VEC[v][2]);
            skip_period();
            for (int p = 0; p < VEC[v][3]; p++) begin
                check_period(VEC[v][0], VEC[v][1], VEC[v][2], -1, 0);
            end
        end

        // R8: a correction change made early in a period waits for the next one
        mod_i  = MOD_W'(19661);
        corr_i = '0;
        dead_i = DT_W'(4);
        skip_period();
        check_period(19661, 0, 4, 10, 12);
        check_period(19661, 12, 4, -1, 0);

        // R5: clamp at full and zero duty
        corr_i = CORR_W'(100);
        skip_period();
        skip_period();
        measure(-1, 0, ha, la, hb, lb, k, tbad);
        check_near("R5 leg A high whole period", ha, real'(2 * HALF), 0.0);
        check_near("R5 leg A low never", la, 0.0, 0.0);
        check_near("R5 leg B high never", hb, 0.0, 0.0);
        check_near("R5 leg B low whole period", lb, real'(2 * HALF), 0.0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule